// File: doc/BRIEF.md
# PS/2 Device-Side Serial Link

This block sits at the device end of a two-wire PS/2 link and generates every clock pulse on the wire. It sends bytes from a one-byte transmit buffer and clocks in command bytes from the host. Both lines are open-drain. The block drives each line only through a pull-low enable and reads each line back through a two-stage synchronizer.

A frame has 11 bits. Before any transfer the block looks at the idle bus. A low clock means the host is inhibiting the link, so nothing starts. A high clock with low data is a host request-to-send, and the block receives the host byte. Only when both lines are high may a queued byte go out.

While transmitting, the block watches the clock line on every cycle of each released phase. If the host forces the clock low before the rising edge of the tenth clock, the block releases both lines and keeps the byte. It sends the byte again from the start once the bus is idle. If the host forces the clock low after that edge, the block treats the transmission as complete. The controller loads bytes with a valid/ready pair and gets each received byte as a one-cycle strobe that carries parity and framing flags.

Top module: `ps2_dev_link`

## Requirements
- R1: After reset, both pull-low enables are inactive, `txReady` is 1 and `rxValid` is 0.
- R2: A transmitted frame is 11 bits, each sampled as the clock line falls. The bits are a 0 start bit, then data bit 0 through bit 7, then a parity bit that makes the count of ones across data and parity odd, then a 1 stop bit.
- R3: Every low phase of the generated clock lasts exactly `HALF_TICKS` cycles, and every released phase of a clock lasts exactly `HALF_TICKS` cycles.
- R4: The data pull-low enable never changes while the clock is being pulled low. The block updates data only at the middle of a released clock phase.
- R5: While the synchronized clock line is low with the bus idle, no transmission starts and neither line is driven.
- R6: When the clock is high and data is low at idle, the block receives the host byte before it sends any queued byte.
- R7: A clock line found low during a released phase before the rising edge of the tenth clock aborts the frame. Both lines are released, `txReady` stays 0, no `txDone` is given, and the same byte is later sent again as a complete frame.
- R8: A clock line forced low after the rising edge of the tenth clock does not abort the frame. The frame completes, `txDone` pulses and `txReady` returns to 1.
- R9: A host frame is received over ten device clocks. These carry data bits 0 to 7, then parity, then stop, with data read late in each released phase. The block then pulses `rxValid` for one cycle with the byte on `rxByte`.
- R10: After reading the stop bit, the block pulls data low for one full extra clock as an acknowledge.
- R11: `rxParityErr` is 1 with `rxValid` when the count of ones across data and parity is even, and 0 otherwise.
- R12: `rxFrameErr` is 1 with `rxValid` when the stop bit read is 0, and 0 otherwise.
- R13: The buffer holds one byte. A `txValid` while `txReady` is 0 is ignored, and a byte loaded at a clock edge makes `txReady` 0 from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ps2ClkIn | input | 1 | Sensed level of the PS/2 clock line |
| ps2DataIn | input | 1 | Sensed level of the PS/2 data line |
| ps2ClkDrvLow | output | 1 | Pull-low enable for the clock line |
| ps2DataDrvLow | output | 1 | Pull-low enable for the data line |
| txByte | input | 8 | Byte offered for transmission |
| txValid | input | 1 | Offer strobe for `txByte` |
| txReady | output | 1 | Transmit buffer is empty |
| txDone | output | 1 | One-cycle pulse when a frame completes |
| rxByte | output | 8 | Last received host byte |
| rxValid | output | 1 | One-cycle pulse when a host byte is received |
| rxParityErr | output | 1 | Parity check failed on the received byte |
| rxFrameErr | output | 1 | Stop bit of the received byte was 0 |

## Verification
Every line result is timed from the generated clock, not from the stimulus. The host model and the frame monitor act only at a rising edge of the clock pull-low enable, which is a falling edge on the wire. They read the wire in the falling clock cycle of the simulation clock that follows that edge.

A loaded byte drops `txReady` one edge after `txValid`. An abort releases both lines within two half-phases plus the synchronizer and settle delay. The bench therefore waits `2*HALF_TICKS+10` cycles before it checks the lines.

`rxValid` arrives one cycle after the end of the acknowledge clock and is checked against the queued host frame. `txDone` is counted against the frames the monitor has completed.

// File: rtl/ps2_link_pkg.sv
package ps2_link_pkg;

  localparam int BIT_W      = 4;
  localparam int LAST_BIT   = 10;
  localparam int ABORT_LAST = 9;
  localparam int RX_LAST    = 9;
  localparam int SETTLE     = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_HI,
    ST_TX_LO,
    ST_TX_END,
    ST_RX_LO,
    ST_RX_HI,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_REST
  } linkState_t;

  typedef struct packed {
    logic tickClr;
    logic bitClr;
    logic bitInc;
    logic rxShift;
    logic rxDone;
    logic txCommit;
    logic txAbort;
  } linkStrobe_t;

endpackage

// File: rtl/ps2_link_dp.sv
module ps2_link_dp
  import ps2_link_pkg::*;
#(
  parameter int HALF_TICKS = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobe_t       st,
  input  logic              ps2ClkIn,
  input  logic              ps2DataIn,
  input  logic [7:0]        txByte,
  input  logic              txValid,
  output logic              txReady,
  output logic              txDone,
  output logic [7:0]        rxByte,
  output logic              rxValid,
  output logic              rxParityErr,
  output logic              rxFrameErr,
  output logic              syncClk,
  output logic              syncData,
  output logic              phaseEnd,
  output logic              firstHalf,
  output logic              settled,
  output logic [BIT_W-1:0]  bitIdx,
  output logic              curBit,
  output logic              prevBit
);

  localparam int TICK_W = $clog2(HALF_TICKS + 1);

  logic [1:0]        clkSync;
  logic [1:0]        dataSync;
  logic [TICK_W-1:0] tick;
  logic              bufFull;
  logic [7:0]        bufData;
  logic [9:0]        rxSh;

  function automatic logic frameAt(input logic [BIT_W-1:0] idx, input logic [7:0] d);
    logic [2:0] pos;
    pos = 3'(idx - 4'd1);
    if (idx == 4'd0)       return 1'b0;
    else if (idx <= 4'd8)  return d[pos];
    else if (idx == 4'd9)  return ~(^d);
    else                   return 1'b1;
  endfunction

  // two-stage line synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= 2'b11;
      dataSync <= 2'b11;
    end else begin
      clkSync  <= {clkSync[0], ps2ClkIn};
      dataSync <= {dataSync[0], ps2DataIn};
    end
  end

  assign syncClk  = clkSync[1];
  assign syncData = dataSync[1];

  // phase tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  tick <= '0;
    else if (st.tickClr || phaseEnd) tick <= '0;
    else                        tick <= tick + 1'b1;
  end

  assign phaseEnd  = (tick == TICK_W'(HALF_TICKS - 1));
  assign firstHalf = (tick <  TICK_W'(HALF_TICKS / 2));
  assign settled   = (tick >= TICK_W'(SETTLE));

  // bit index within the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitIdx <= '0;
    else if (st.bitClr) bitIdx <= '0;
    else if (st.bitInc) bitIdx <= bitIdx + 1'b1;
  end

  // one-byte transmit buffer, kept on abort
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufData <= '0;
      txDone  <= 1'b0;
    end else begin
      txDone <= st.txCommit;
      if (st.txCommit) begin
        bufFull <= 1'b0;
      end else if (txValid && !bufFull) begin
        bufFull <= 1'b1;
        bufData <= txByte;
      end
    end
  end

  assign txReady = !bufFull;
  assign curBit  = frameAt(bitIdx, bufData);
  assign prevBit = (bitIdx == '0) ? 1'b1 : frameAt(bitIdx - 1'b1, bufData);

  // receive shifter and result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh        <= '0;
      rxByte      <= '0;
      rxValid     <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (st.rxShift) rxSh <= {syncData, rxSh[9:1]};
      if (st.rxDone) begin
        rxByte      <= rxSh[7:0];
        rxParityErr <= ~(^rxSh[8:0]);
        rxFrameErr  <= ~rxSh[9];
        rxValid     <= 1'b1;
      end
    end
  end

  // R7
  abort_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.txAbort |=> (bufFull && $stable(bufData)));

  // R13
  busy_ignores_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && txValid && !st.txCommit) |=> (bufFull && $stable(bufData)));

  // R9
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/ps2_link_ctrl.sv
module ps2_link_ctrl
  import ps2_link_pkg::*;
#(
  parameter int HALF_TICKS = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncClk,
  input  logic             syncData,
  input  logic             phaseEnd,
  input  logic             firstHalf,
  input  logic             settled,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic             curBit,
  input  logic             prevBit,
  input  logic             bufFull,
  output linkStrobe_t      st,
  output logic             clkDrvLow,
  output logic             dataDrvLow
);

  localparam int RUN_W = $clog2(HALF_TICKS + 2);

  linkState_t state, nxt;
  logic       clkLowNxt, dataLowNxt;

  always_comb begin
    nxt        = state;
    st         = '0;
    clkLowNxt  = 1'b0;
    dataLowNxt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (syncClk && !syncData) begin
          nxt = ST_RX_LO; st.tickClr = 1'b1; st.bitClr = 1'b1;
        end else if (syncClk && syncData && bufFull) begin
          nxt = ST_TX_HI; st.tickClr = 1'b1; st.bitClr = 1'b1;
        end
      end
      ST_TX_HI: begin
        dataLowNxt = firstHalf ? ~prevBit : ~curBit;
        if (settled && !syncClk && bitIdx <= BIT_W'(ABORT_LAST)) begin
          nxt = ST_REST; st.tickClr = 1'b1; st.txAbort = 1'b1;
          dataLowNxt = 1'b0;
        end else if (phaseEnd) begin
          nxt = ST_TX_LO; st.tickClr = 1'b1;
        end
      end
      ST_TX_LO: begin
        clkLowNxt  = 1'b1;
        dataLowNxt = ~curBit;
        if (phaseEnd) begin
          st.tickClr = 1'b1;
          if (bitIdx == BIT_W'(LAST_BIT)) nxt = ST_TX_END;
          else begin nxt = ST_TX_HI; st.bitInc = 1'b1; end
        end
      end
      ST_TX_END: begin
        if (phaseEnd) begin
          nxt = ST_IDLE; st.tickClr = 1'b1; st.txCommit = 1'b1;
        end
      end
      ST_RX_LO: begin
        clkLowNxt = 1'b1;
        if (phaseEnd) begin nxt = ST_RX_HI; st.tickClr = 1'b1; end
      end
      ST_RX_HI: begin
        if (phaseEnd) begin
          st.tickClr = 1'b1; st.rxShift = 1'b1;
          if (bitIdx == BIT_W'(RX_LAST)) nxt = ST_ACK_LO;
          else begin nxt = ST_RX_LO; st.bitInc = 1'b1; end
        end
      end
      ST_ACK_LO: begin
        clkLowNxt = 1'b1; dataLowNxt = 1'b1;
        if (phaseEnd) begin nxt = ST_ACK_HI; st.tickClr = 1'b1; end
      end
      ST_ACK_HI: begin
        dataLowNxt = 1'b1;
        if (phaseEnd) begin
          nxt = ST_REST; st.tickClr = 1'b1; st.rxDone = 1'b1;
        end
      end
      ST_REST: begin
        if (phaseEnd) begin nxt = ST_IDLE; st.tickClr = 1'b1; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      clkDrvLow  <= 1'b0;
      dataDrvLow <= 1'b0;
    end else begin
      state      <= nxt;
      clkDrvLow  <= clkLowNxt;
      dataDrvLow <= dataLowNxt;
    end
  end

  // checker: length of each driven-low clock phase
  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowRun <= '0;
    else if (clkDrvLow) lowRun <= lowRun + 1'b1;
    else                lowRun <= '0;
  end

  // R3
  low_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkDrvLow) |-> (lowRun == RUN_W'(HALF_TICKS)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkDrvLow && $past(clkDrvLow)) |-> $stable(dataDrvLow));

  // R5
  inhibit_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !syncClk) |=> (state == ST_IDLE));

  // R6
  rts_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && syncClk && !syncData) |=> (state == ST_RX_LO));

endmodule

// File: rtl/ps2_dev_link.sv
module ps2_dev_link
  import ps2_link_pkg::*;
#(
  parameter int HALF_TICKS = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ps2ClkIn,
  input  logic       ps2DataIn,
  output logic       ps2ClkDrvLow,
  output logic       ps2DataDrvLow,
  input  logic [7:0] txByte,
  input  logic       txValid,
  output logic       txReady,
  output logic       txDone,
  output logic [7:0] rxByte,
  output logic       rxValid,
  output logic       rxParityErr,
  output logic       rxFrameErr
);

  linkStrobe_t      st;
  logic             syncClk, syncData, phaseEnd, firstHalf, settled;
  logic             curBit, prevBit;
  logic [BIT_W-1:0] bitIdx;

  ps2_link_dp #(.HALF_TICKS(HALF_TICKS)) uDp (
    .clk(clk), .rstN(rstN), .st(st),
    .ps2ClkIn(ps2ClkIn), .ps2DataIn(ps2DataIn),
    .txByte(txByte), .txValid(txValid), .txReady(txReady), .txDone(txDone),
    .rxByte(rxByte), .rxValid(rxValid), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr),
    .syncClk(syncClk), .syncData(syncData), .phaseEnd(phaseEnd),
    .firstHalf(firstHalf), .settled(settled), .bitIdx(bitIdx),
    .curBit(curBit), .prevBit(prevBit)
  );

  ps2_link_ctrl #(.HALF_TICKS(HALF_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .syncClk(syncClk), .syncData(syncData), .phaseEnd(phaseEnd),
    .firstHalf(firstHalf), .settled(settled), .bitIdx(bitIdx),
    .curBit(curBit), .prevBit(prevBit), .bufFull(!txReady),
    .st(st), .clkDrvLow(ps2ClkDrvLow), .dataDrvLow(ps2DataDrvLow)
  );

endmodule

// File: tb/sim_ps2_dev_link.sv
module sim_ps2_dev_link;

  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostClkLow = 1'b0;
  logic       hostDataLow = 1'b0;
  logic       ps2ClkDrvLow, ps2DataDrvLow;
  logic [7:0] txByte = '0;
  logic       txValid = 1'b0;
  logic       txReady, txDone, rxValid, rxParityErr, rxFrameErr;
  logic [7:0] rxByte;
  logic       clkLine, dataLine;

  int checks = 0;
  int errors = 0;

  assign clkLine  = ~(ps2ClkDrvLow | hostClkLow);
  assign dataLine = ~(ps2DataDrvLow | hostDataLow);

  always #10 clk = ~clk;

  ps2_dev_link #(.HALF_TICKS(HALF)) u0 (
    .clk(clk), .rstN(rstN), .ps2ClkIn(clkLine), .ps2DataIn(dataLine),
    .ps2ClkDrvLow(ps2ClkDrvLow), .ps2DataDrvLow(ps2DataDrvLow),
    .txByte(txByte), .txValid(txValid), .txReady(txReady), .txDone(txDone),
    .rxByte(rxByte), .rxValid(rxValid), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboards
  logic [7:0] txQ[$];
  logic [9:0] rxQ[$];
  bit   hostSending = 1'b0;
  int   clearReq = 0;
  int   clearSeen = 0;
  int   bitCnt = 0;
  int   txFrames = 0;
  int   doneCnt = 0;
  int   rxCnt = 0;
  logic [10:0] frame;
  logic monPrev = 1'b0;
  int   lowCnt = 0;

  // monitor: device frames, clock widths, received bytes
  always @(negedge clk) begin
    if (!rstN) begin
      monPrev = 1'b0;
    end else begin
      if (clearReq != clearSeen) begin
        clearSeen = clearReq;
        bitCnt = 0;
      end
      if (ps2ClkDrvLow) lowCnt++;
      if (!ps2ClkDrvLow && monPrev) begin
        // R3 low phase width
        check(lowCnt == HALF, "R3 low phase", lowCnt, HALF);
        lowCnt = 0;
      end
      if (ps2ClkDrvLow && !monPrev && !hostSending) begin
        frame[bitCnt] = dataLine;
        bitCnt++;
        if (bitCnt == 11) begin
          logic [7:0] exp;
          bitCnt = 0;
          txFrames++;
          exp = (txQ.size() != 0) ? txQ.pop_front() : 8'hxx;
          check(frame[0] == 1'b0, "R2 start", int'(frame[0]), 0);
          check(frame[8:1] === exp, "R2 data", int'(frame[8:1]), int'(exp));
          check(frame[9] == ~(^frame[8:1]), "R2 parity", int'(frame[9]), int'(~(^frame[8:1])));
          check(frame[10] == 1'b1, "R2 stop", int'(frame[10]), 1);
        end
      end
      monPrev = ps2ClkDrvLow;
      if (txDone) doneCnt++;
      if (rxValid) begin
        logic [9:0] e;
        rxCnt++;
        e = (rxQ.size() != 0) ? rxQ.pop_front() : 10'h3ff;
        check(rxByte == e[9:2], "R9 byte", int'(rxByte), int'(e[9:2]));
        check(rxParityErr == e[1], "R11 parity flag", int'(rxParityErr), int'(e[1]));
        check(rxFrameErr == e[0], "R12 frame flag", int'(rxFrameErr), int'(e[0]));
      end
    end
  end

  task automatic pushTx(input logic [7:0] b);
    while (!txReady) @(negedge clk);
    txQ.push_back(b);
    txByte = b; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    check(txReady == 1'b0, "R13 ready drop", int'(txReady), 0);
  endtask

  task automatic waitTxIdle();
    while (txQ.size() != 0 || !txReady) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic waitDevFall();
    do @(negedge clk); while (ps2ClkDrvLow);
    do @(negedge clk); while (!ps2ClkDrvLow);
  endtask

  task automatic hostSend(input logic [7:0] b, input bit badPar, input bit badStop);
    logic [9:0] bits;
    logic par;
    par = ~(^b) ^ badPar;
    bits = {~badStop, par, b};
    rxQ.push_back({b, badPar, badStop});
    hostSending = 1'b1;
    hostClkLow = 1'b1;
    repeat (40) @(negedge clk);
    hostDataLow = 1'b1;
    @(negedge clk);
    hostClkLow = 1'b0;
    for (int k = 0; k < 10; k++) begin
      waitDevFall();
      hostDataLow = ~bits[k];
    end
    waitDevFall();
    hostDataLow = 1'b0;
    // R10 acknowledge driven during the extra clock
    check(ps2DataDrvLow == 1'b1, "R10 ack", int'(ps2DataDrvLow), 1);
    do @(negedge clk); while (ps2DataDrvLow);
    hostSending = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int framesBefore, rxBefore, doneBefore;
    bit anyDrive;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ps2ClkDrvLow == 1'b0, "R1 clk drive", int'(ps2ClkDrvLow), 0);
    check(ps2DataDrvLow == 1'b0, "R1 data drive", int'(ps2DataDrvLow), 0);
    check(txReady == 1'b1, "R1 ready", int'(txReady), 1);
    check(rxValid == 1'b0, "R1 rx valid", int'(rxValid), 0);

    // R2 frames with several patterns; R13 offer while busy is dropped
    pushTx(8'hA5);
    txByte = 8'h77; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    waitTxIdle();
    pushTx(8'h01); waitTxIdle();
    pushTx(8'hFF); waitTxIdle();
    pushTx(8'h00); waitTxIdle();
    repeat (300) @(negedge clk);
    check(txFrames == 4, "R13 frames sent", txFrames, 4);
    check(doneCnt == 4, "R8 done count", doneCnt, 4);

    // R5 inhibit holds off the start
    hostClkLow = 1'b1;
    repeat (30) @(negedge clk);
    pushTx(8'h5E);
    anyDrive = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (ps2ClkDrvLow || ps2DataDrvLow) anyDrive = 1'b1;
    end
    check(!anyDrive, "R5 inhibit", int'(anyDrive), 0);
    check(txReady == 1'b0, "R5 byte held", int'(txReady), 0);
    hostClkLow = 1'b0;
    waitTxIdle();

    // R9 good byte, R11 parity error, R12 stop error
    hostSend(8'h96, 1'b0, 1'b0);
    hostSend(8'h3B, 1'b1, 1'b0);
    hostSend(8'hC4, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    check(rxCnt == 3, "R9 rx count", rxCnt, 3);

    // R6 request-to-send wins over a queued byte
    framesBefore = txFrames;
    rxBefore = rxCnt;
    hostSending = 1'b1;
    hostClkLow = 1'b1;
    repeat (10) @(negedge clk);
    pushTx(8'h3C);
    hostSend(8'h69, 1'b0, 1'b0);
    check(rxCnt == rxBefore + 1, "R6 rx first", rxCnt, rxBefore + 1);
    check(txFrames == framesBefore, "R6 tx waits", txFrames, framesBefore);
    waitTxIdle();
    check(txFrames == framesBefore + 1, "R6 tx after", txFrames, framesBefore + 1);

    // R7 abort before the tenth clock, then resend
    doneBefore = doneCnt;
    framesBefore = txFrames;
    pushTx(8'h5A);
    while (bitCnt != 5) @(negedge clk);
    hostClkLow = 1'b1;
    repeat (2 * HALF + 10) @(negedge clk);
    check(ps2ClkDrvLow == 1'b0, "R7 clk released", int'(ps2ClkDrvLow), 0);
    check(ps2DataDrvLow == 1'b0, "R7 data released", int'(ps2DataDrvLow), 0);
    check(txReady == 1'b0, "R7 byte kept", int'(txReady), 0);
    clearReq++;
    repeat (200) @(negedge clk);
    check(doneCnt == doneBefore, "R7 no done", doneCnt, doneBefore);
    hostClkLow = 1'b0;
    waitTxIdle();
    check(txFrames == framesBefore + 1, "R7 resent", txFrames, framesBefore + 1);
    check(doneCnt == doneBefore + 1, "R7 done after resend", doneCnt, doneBefore + 1);

    // R8 contention after the tenth rising edge completes the frame
    doneBefore = doneCnt;
    framesBefore = txFrames;
    pushTx(8'hC3);
    while (bitCnt != 10) @(negedge clk);
    do @(negedge clk); while (ps2ClkDrvLow);
    hostClkLow = 1'b1;
    repeat (3 * HALF + 20) @(negedge clk);
    check(txReady == 1'b1, "R8 ready", int'(txReady), 1);
    check(doneCnt == doneBefore + 1, "R8 done", doneCnt, doneBefore + 1);
    check(txFrames == framesBefore + 1, "R8 frame", txFrames, framesBefore + 1);
    hostClkLow = 1'b0;
    repeat (200) @(negedge clk);
    check(txFrames == framesBefore + 1, "R8 no resend", txFrames, framesBefore + 1);
    check(txQ.size() == 0 && rxQ.size() == 0, "R2 queues drained",
          txQ.size() + rxQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule